// File: doc/BRIEF.md
# Converter Output Data Formatter

This block takes 12-bit samples from a converter core and turns them into serial bits on one or two output lanes. For every accepted word it picks one of three sources. The first is the live sample. The second is a fixed test word. The third is a test word assembled from two user pattern fields. A live sample may then be recoded from offset binary into two's complement. The chosen word is shifted out MSB first.

In single-lane mode the whole word leaves on lane 1, one bit per cycle. In dual-lane mode the word is split across both lanes, two bits per cycle, so a word takes half the cycles. Each lane has its own output enable, which the pad logic uses as a tri-state control. A lane with its enable low is meant to be high-impedance.

Samples arrive on a valid/ready stream. A sample is taken on a clock edge where both valid and ready are high. Ready is high while the block is idle and during the final cycle of the word in flight, so a steady source is serialized with no gap between words. While ready is low, the source must hold valid and data steady. The control fields and pattern fields are plain level inputs. They are sampled together with each accepted word, so a change made in the middle of a word only affects the words accepted after it.

Top module: `adc_out_formatter`

## Requirements
- R1: After reset and whenever no word is in flight, ln1_oe, ln0_oe, ln1_d and ln0_d are all 0 and in_ready is 1.
- R2: With cfg_mode = 2'b00 and cfg_signed = 0, the transmitted word equals in_sample unchanged (offset binary).
- R3: With cfg_mode = 2'b00 and cfg_signed = 1, the transmitted word equals in_sample with bit 11 inverted (two's complement).
- R4: With cfg_mode = 2'b01, the transmitted word is 12'hA63 (binary 101001100011, MSB first). This holds for any in_sample and either cfg_signed value.
- R5: With cfg_mode = 2'b10, the transmitted word is {upat_hi[3:0], upat_lo[7:0]}, sent without format conversion.
- R6: With the reserved cfg_mode = 2'b11, the transmitted word is all zeros.
- R7: With cfg_one_lane = 1, a word takes 12 cycles. ln1_oe is 1 and ln1_d carries bits 11 down to 0 in that order. ln0_oe and ln0_d stay 0.
- R8: With cfg_one_lane = 0, a word takes 6 cycles with both enables 1. In cycle k (k = 0..5), ln1_d carries word bit 11-2k and ln0_d carries word bit 10-2k.
- R9: A sample is accepted on an edge where in_valid and in_ready are both 1. In the cycle after that edge, the first bit or bits appear and word_sof is 1 for that one cycle. in_ready is 1 only when idle or in the last cycle of a word, so back-to-back words have no idle cycle between them.
- R10: cfg_mode, cfg_signed, cfg_one_lane, upat_hi and upat_lo are sampled only at acceptance. Changing them while a word is in flight does not alter that word's bits, its lane use or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_sample | input | 12 | Sample from the converter core, offset binary |
| cfg_mode | input | 2 | Source select: 00 live, 01 fixed pattern, 10 user pattern, 11 reserved (zeros) |
| cfg_signed | input | 1 | 1 selects two's complement for live samples |
| cfg_one_lane | input | 1 | 1 selects single-lane output on lane 1 |
| upat_hi | input | 4 | User pattern bits 11:8 |
| upat_lo | input | 8 | User pattern bits 7:0 |
| ln1_d | output | 1 | Lane 1 serial data |
| ln1_oe | output | 1 | Lane 1 drive enable |
| ln0_d | output | 1 | Lane 0 serial data |
| ln0_oe | output | 1 | Lane 0 drive enable (0 means tri-state) |
| word_sof | output | 1 | High in the first cycle of every word |

## Verification
Every one of the 4096 sample values is sent in live mode three times: dual-lane offset binary, dual-lane two's complement and single-lane two's complement. This shows whether bit 11 alone is recoded and whether the two lane bit orders interleave correctly. The fixed, user and reserved modes are sent with several different samples, user values and format settings. These words show whether the live data or the format bit leaks into a test word. Some words have their control and pattern inputs flipped while the word is in flight, which tells a design that samples its configuration at acceptance apart from one that follows the pins. Words are sent back to back, so any idle cycle or misplaced start marker between words is caught.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

  typedef enum logic [1:0] {
    MODE_LIVE  = 2'b00,
    MODE_FIXED = 2'b01,
    MODE_USER  = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

endpackage

// File: rtl/ofmt_src_sel.sv
module ofmt_src_sel #(
  parameter int SMP_W = 12,
  parameter int ULO_W = 8,
  parameter logic [SMP_W-1:0] FIX_PAT = 12'hA63,
  localparam int UHI_W = SMP_W - ULO_W
) (
  input  logic [1:0]       mode,
  input  logic             to_signed,
  input  logic [SMP_W-1:0] sample,
  input  logic [UHI_W-1:0] pat_hi,
  input  logic [ULO_W-1:0] pat_lo,
  output logic [SMP_W-1:0] word
);
  import ofmt_pkg::*;

  always_comb begin
    case (mode_e'(mode))
      MODE_LIVE:  word = to_signed ? {~sample[SMP_W-1], sample[SMP_W-2:0]} : sample;
      MODE_FIXED: word = FIX_PAT;
      MODE_USER:  word = {pat_hi, pat_lo};
      default:    word = '0;
    endcase
  end

endmodule

// File: rtl/ofmt_ser.sv
module ofmt_ser #(
  parameter int SMP_W = 12,
  localparam int CW = $clog2(SMP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SMP_W-1:0] word,
  input  logic             one_lane,
  output logic             busy,
  output logic             last,
  output logic             ln1_d,
  output logic             ln1_oe,
  output logic             ln0_d,
  output logic             ln0_oe,
  output logic             sof
);
  localparam logic [CW-1:0] SPAN1 = CW'(SMP_W - 1);
  localparam logic [CW-1:0] SPAN2 = CW'(SMP_W / 2 - 1);

  logic [SMP_W-1:0] sh;
  logic [CW-1:0]    cnt;
  logic             single_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      single_q <= 1'b0;
      sof      <= 1'b0;
    end else begin
      sof <= load;
      if (load) begin
        sh       <= word;
        cnt      <= one_lane ? SPAN1 : SPAN2;
        busy     <= 1'b1;
        single_q <= one_lane;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
          sh  <= single_q ? {sh[SMP_W-2:0], 1'b0} : {sh[SMP_W-3:0], 2'b00};
        end
      end
    end
  end

  assign last   = busy && (cnt == '0);
  assign ln1_oe = busy;
  assign ln0_oe = busy && !single_q;
  assign ln1_d  = busy && sh[SMP_W-1];
  assign ln0_d  = busy && !single_q && sh[SMP_W-2];

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter #(
  parameter int SMP_W = 12,
  parameter int ULO_W = 8,
  parameter logic [SMP_W-1:0] FIX_PAT = 12'hA63,
  localparam int UHI_W = SMP_W - ULO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_sample,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_signed,
  input  logic             cfg_one_lane,
  input  logic [UHI_W-1:0] upat_hi,
  input  logic [ULO_W-1:0] upat_lo,
  output logic             ln1_d,
  output logic             ln1_oe,
  output logic             ln0_d,
  output logic             ln0_oe,
  output logic             word_sof
);
  logic [SMP_W-1:0] fmt_word;
  logic             busy;
  logic             last;
  logic             load;

  ofmt_src_sel #(.SMP_W(SMP_W), .ULO_W(ULO_W), .FIX_PAT(FIX_PAT)) u_sel (
    .mode      (cfg_mode),
    .to_signed (cfg_signed),
    .sample    (in_sample),
    .pat_hi    (upat_hi),
    .pat_lo    (upat_lo),
    .word      (fmt_word)
  );

  assign in_ready = !busy || last;
  assign load     = in_valid && in_ready;

  ofmt_ser #(.SMP_W(SMP_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .word     (fmt_word),
    .one_lane (cfg_one_lane),
    .busy     (busy),
    .last     (last),
    .ln1_d    (ln1_d),
    .ln1_oe   (ln1_oe),
    .ln0_d    (ln0_d),
    .ln0_oe   (ln0_oe),
    .sof      (word_sof)
  );

endmodule

// File: rtl/adc_out_formatter_chk.sv
module adc_out_formatter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ln1_d,
  input logic ln1_oe,
  input logic ln0_d,
  input logic ln0_oe,
  input logic word_sof
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ln1_oe |-> (!ln0_oe && !ln1_d && !ln0_d && in_ready));

  // R7
  lane0_follows_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ln0_oe |-> ln1_oe);

  // R9
  accept_starts_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (word_sof && ln1_oe));

  // R9
  sof_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_sof |-> $past(in_valid && in_ready));

  // R10
  word_holds_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ln1_oe && !in_ready) |=> (ln1_oe && $stable(ln0_oe)));

endmodule

bind adc_out_formatter adc_out_formatter_chk u_chk (.*);

// File: tb/adc_out_formatter_bench.sv
module adc_out_formatter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_sample = '0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_signed = 1'b0;
  logic        cfg_one_lane = 1'b0;
  logic [3:0]  upat_hi = '0;
  logic [7:0]  upat_lo = '0;
  logic        ln1_d, ln1_oe, ln0_d, ln0_oe, word_sof;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_formatter u_adc_out_formatter (.*);

  task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] model(input logic [11:0] d);
    case (cfg_mode)
      2'b00:   return cfg_signed ? (d ^ 12'h800) : d;
      2'b01:   return 12'hA63;
      2'b10:   return {upat_hi, upat_lo};
      default: return 12'h000;
    endcase
  endfunction

  function automatic string mode_tag();
    case (cfg_mode)
      2'b00:   return cfg_signed ? "R3" : "R2";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a falling edge; returns at the falling edge showing the word's last bits.
  task automatic send(input logic [11:0] d, input bit disturb);
    logic [11:0] exp, got;
    logic        one;
    logic [1:0]  s_mode;
    logic        s_sgn, s_one;
    logic [3:0]  s_hi;
    logic [7:0]  s_lo;
    string       tag;
    int          steps;
    bit          lane_ok, rdy_ok;
    exp = model(d);
    tag = disturb ? "R10" : mode_tag();
    one = cfg_one_lane;
    s_mode = cfg_mode; s_sgn = cfg_signed; s_one = cfg_one_lane; s_hi = upat_hi; s_lo = upat_lo;
    in_sample = d;
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    in_sample = ~d;
    chk(word_sof === 1'b1, "R9 word_sof", {11'd0, word_sof}, 12'd1);
    if (disturb) begin
      cfg_mode = ~cfg_mode; cfg_signed = ~cfg_signed; cfg_one_lane = ~cfg_one_lane;
      upat_hi = ~upat_hi; upat_lo = ~upat_lo;
    end
    steps = one ? 12 : 6;
    got = '0; lane_ok = 1'b1; rdy_ok = 1'b1;
    for (int i = 0; i < steps; i++) begin
      if (i > 0) @(negedge clk);
      if (ln1_oe !== 1'b1 || ln0_oe !== !one) lane_ok = 1'b0;
      if (one) begin
        got[11-i] = ln1_d;
        if (ln0_d !== 1'b0) lane_ok = 1'b0;
      end else begin
        got[11-2*i] = ln1_d;
        got[10-2*i] = ln0_d;
      end
      if (in_ready !== (i == steps - 1)) rdy_ok = 1'b0;
    end
    cfg_mode = s_mode; cfg_signed = s_sgn; cfg_one_lane = s_one; upat_hi = s_hi; upat_lo = s_lo;
    chk(got === exp, tag, got, exp);
    chk(lane_ok, one ? "R7 lane use" : "R8 lane use", {11'd0, lane_ok}, 12'd1);
    chk(rdy_ok, "R9 ready timing", {11'd0, rdy_ok}, 12'd1);
  endtask

  task automatic idle_check(input string tag);
    chk(ln1_oe === 1'b0 && ln0_oe === 1'b0 && ln1_d === 1'b0 && ln0_d === 1'b0 && in_ready === 1'b1,
        tag, {7'd0, ln1_oe, ln0_oe, ln1_d, ln0_d, in_ready}, 12'h001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 reset");

    // Live, dual lane, offset binary: full sweep
    cfg_mode = 2'b00; cfg_signed = 1'b0; cfg_one_lane = 1'b0;
    for (int v = 0; v < 4096; v++) send(12'(v), 1'b0);
    @(negedge clk);
    idle_check("R1 idle");

    // Live, dual lane, two's complement: full sweep
    cfg_signed = 1'b1;
    for (int v = 0; v < 4096; v++) send(12'(v), 1'b0);

    // Live, single lane, two's complement: full sweep
    cfg_one_lane = 1'b1;
    for (int v = 0; v < 4096; v++) send(12'(v), 1'b0);

    // Live, single lane, offset binary corners
    cfg_signed = 1'b0;
    send(12'h000, 1'b0); send(12'hFFF, 1'b0); send(12'h800, 1'b0); send(12'h7FF, 1'b0);

    // Test modes in both lane settings and both formats
    for (int ln = 0; ln < 2; ln++) begin
      for (int sg = 0; sg < 2; sg++) begin
        cfg_one_lane = ln[0]; cfg_signed = sg[0];
        cfg_mode = 2'b01;
        send(12'h000, 1'b0); send(12'h5A5, 1'b0); send(12'hFFF, 1'b0);
        cfg_mode = 2'b10;
        upat_hi = 4'h9; upat_lo = 8'h3C; send(12'h123, 1'b0);
        upat_hi = 4'hF; upat_lo = 8'h00; send(12'hABC, 1'b0);
        upat_hi = 4'h0; upat_lo = 8'hFF; send(12'h800, 1'b0);
        cfg_mode = 2'b11;
        send(12'hFFF, 1'b0); send(12'h555, 1'b0);
      end
    end

    // Configuration flipped mid-word
    for (int m = 0; m < 4; m++) begin
      cfg_mode = 2'(m); upat_hi = 4'h6; upat_lo = 8'hC1;
      cfg_one_lane = 1'b0; cfg_signed = 1'b0; send(12'h3D7, 1'b1);
      cfg_one_lane = 1'b1; cfg_signed = 1'b1; send(12'hC28, 1'b1);
    end
    @(negedge clk);
    idle_check("R1 idle end");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 12'h000, 12'h001);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule